// File: doc/BRIEF.md
# Serial presence-detect protection and page command decoder

This block sits behind the bit engine of a two-wire memory slave that fronts a 512-byte array. The array is seen as two 256-byte pages, and each page holds two 128-byte blocks. The bit engine hands over every received byte as a one-cycle strobe, together with the byte's position in the transaction (select, address, data). It also signals a stop condition as its own strobe. The decoder then decides whether the byte gets an acknowledge.

The first byte of a transaction is either a memory access or a control command. A memory access is accepted only when its slave-address field matches the strap pins. A control command can protect one block, clear all protection, query the protection of one block, select a page or query the page. Queries return their answer only as acknowledge or no-acknowledge. The block keeps the four protect bits and the page bit. Writes into a protected block are refused. The block requests an internal write cycle when a write that may proceed is closed by a stop.

The protect bits survive the soft/bus reset. They return to their initial value only on the power-on reset input. This models storage that keeps its contents across a power cycle.

Top module: `spd_prot_decoder`

## Requirements
- R1: A select byte with bits 7..4 = 1010 gets acknowledge exactly when bits 3..1 equal `strapPins`. On a mismatch, that byte and every following byte of the transaction get no-acknowledge, and a stop raises no write-cycle request.
- R2: A memory write (select bit 0 = 0) to an unprotected block acknowledges the select, address and data bytes. A stop that follows an acknowledged data byte raises `wrCycleReq` for one cycle, in the cycle after the stop strobe. A stop that follows only the address byte raises no request.
- R3: The target block of a memory write is page*2 + address bit 7. When that block is protected, the select and address bytes are acknowledged, data bytes get no-acknowledge, and the stop raises no request.
- R4: Select byte 0110 with bit 0 = 0 and bits 3..1 = 001, 100, 101 or 000 protects block 0, 1, 2 or 3 respectively. The command is taken only while `hvPresent` is 1. If the block is unprotected, all three bytes are acknowledged, the stop raises a request and the block becomes protected. If the block is already protected, all three bytes get no-acknowledge and the stop raises no request.
- R5: Without `hvPresent`, a protect or clear-all command gets no-acknowledge and changes no protect bit.
- R6: Select byte 0110 011 0 with `hvPresent` acknowledges all three bytes and, on the stop, raises a request and clears all four protect bits, whether or not any bit was set.
- R7: Select byte 0110 with bit 0 = 1 and bits 3..1 using the block coding of R4 gets acknowledge when that block is unprotected and no-acknowledge when it is protected, regardless of `hvPresent`. It raises no write-cycle request.
- R8: 0110 110 0 selects page 0 and 0110 111 0 selects page 1. Either is acknowledged, takes effect at the select byte, drives `pageSel`, and raises no request. 0110 110 1 gets acknowledge when page 0 is selected and no-acknowledge when page 1 is selected.
- R9: The remaining 0110 codes (010 x, 011 1, 111 1) and any other value of bits 7..4 get no-acknowledge and change neither the protect bits nor the page.
- R10: After either reset, `ackOut` and `wrCycleReq` are 0 and the page is 0. `rstN` keeps the protect bits, and `porN` returns them to the initial value (all unprotected by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, synchronous; also resets protect bits |
| rstN | input | 1 | Soft/bus reset, active low, synchronous; keeps protect bits |
| byteValid | input | 1 | One-cycle strobe: a received byte is on byteData |
| byteData | input | 8 | Received byte, bit 7 was first on the wire |
| bytePos | input | 2 | Position of the byte: 0 select, 1 address, 2 or 3 data |
| stopValid | input | 1 | One-cycle strobe: stop condition seen |
| strapPins | input | 3 | Slave-address strap pins |
| hvPresent | input | 1 | High voltage detected on the lowest strap pin |
| ackOut | output | 1 | Acknowledge decision for the last byte; cleared by stop |
| wrCycleReq | output | 1 | One-cycle request for an internal write cycle |
| pageSel | output | 1 | Selected page of the array |

## Verification
The situation hardest to reach from the ports is a protect command on a block that is already protected. This needs an earlier command with the high-voltage flag that ran to its stop. The stimulus table therefore protects block 1 and then repeats the same command, checking no-acknowledge on all three bytes and the missing write request. The same setup is needed to show that a memory write into a protected block is refused. Because the block index depends on the page bit, the table also switches to page 1, protects block 2 and writes to both halves of that page. Retention of the protect bits is shown by protecting a block, pulsing the soft reset and querying the block's status.

// File: rtl/spd_prot_pkg.sv
package spd_prot_pkg;
  localparam int BLK_N = 4;
  localparam int BLK_W = $clog2(BLK_N);

  localparam logic [3:0] TYPE_MEM  = 4'b1010;
  localparam logic [3:0] TYPE_CTRL = 4'b0110;
  localparam logic [2:0] SUB_CLR   = 3'b011;
  localparam logic [2:0] SUB_PG0   = 3'b110;
  localparam logic [2:0] SUB_PG1   = 3'b111;

  typedef enum logic [2:0] {
    K_IDLE, K_MEMW, K_MEMR, K_SET, K_CLR, K_PAGE, K_QUERY
  } txnKind_t;

  typedef struct packed {
    logic [BLK_N-1:0] setMask;
    logic             clrAll;
    logic             pageWr;
    logic             pageVal;
  } ctrlStrobe_t;

  typedef struct packed {
    logic             valid;
    logic [BLK_W-1:0] idx;
  } blkMap_t;

  // Block coding of the command field is not binary: 001,100,101,000 -> 0..3
  function automatic blkMap_t blkOf(input logic [2:0] sub);
    blkMap_t m;
    m.valid = 1'b1;
    case (sub)
      3'b001:  m.idx = 2'd0;
      3'b100:  m.idx = 2'd1;
      3'b101:  m.idx = 2'd2;
      3'b000:  m.idx = 2'd3;
      default: begin m.valid = 1'b0; m.idx = 2'd0; end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/spd_prot_state.sv
module spd_prot_state
  import spd_prot_pkg::*;
#(
  parameter logic [BLK_N-1:0] PROT_INIT = '0
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  output logic [BLK_N-1:0] protQ,
  output logic             pageQ
);
  always_ff @(posedge clk) begin
    if (!porN) begin
      protQ <= PROT_INIT;
    end else if (strb.clrAll) begin
      protQ <= '0;
    end else begin
      protQ <= protQ | strb.setMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!porN || !rstN) begin
      pageQ <= 1'b0;
    end else if (strb.pageWr) begin
      pageQ <= strb.pageVal;
    end
  end

  // R6: a protect bit falls only through the clear-all strobe
  p_prot_fall_only_clear_r6: assert property (@(posedge clk) disable iff (!porN)
    ((($past(protQ) & ~protQ) != '0) |-> $past(strb.clrAll)));

  // R4: a protect bit rises only for the block named by the set strobe
  p_prot_rise_only_set_r4: assert property (@(posedge clk) disable iff (!porN)
    (((protQ & ~$past(protQ) & ~$past(strb.setMask)) == '0)));

  // R8: the page changes only on a page-select strobe
  p_page_change_r8: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (!$stable(pageQ) |-> $past(strb.pageWr)));
endmodule

// File: rtl/spd_cmd_ctrl.sv
module spd_cmd_ctrl
  import spd_prot_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int POS_W   = 2,
  parameter int STRAP_W = 3
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [POS_W-1:0]  bytePos,
  input  logic              stopValid,
  input  logic [STRAP_W-1:0] strapPins,
  input  logic              hvPresent,
  input  logic [BLK_N-1:0]  protQ,
  input  logic              pageQ,
  output ctrlStrobe_t       strb,
  output logic              ackOut,
  output logic              wrCycleReq
);
  localparam logic [POS_W-1:0] POS_SEL  = POS_W'(0);
  localparam logic [POS_W-1:0] POS_ADDR = POS_W'(1);

  logic [3:0]       devType;
  logic [2:0]       sub;
  logic             rwBit;
  blkMap_t          bm;

  txnKind_t         kindQ, selKind;
  logic             okQ, selOk, selAck;
  logic [BLK_W-1:0] blkQ;
  logic             armedQ;
  logic             pageWrC, pageValC;
  logic             byteAck, byteArm;
  logic [BLK_W-1:0] memBlk;
  logic             takeByte;

  assign devType  = byteData[BYTE_W-1 -: 4];
  assign sub      = byteData[3:1];
  assign rwBit    = byteData[0];
  assign bm       = blkOf(sub);
  assign memBlk   = {pageQ, byteData[BYTE_W-1]};
  assign takeByte = byteValid && !stopValid;

  // Select byte decode
  always_comb begin
    selAck   = 1'b0;
    selOk    = 1'b0;
    selKind  = K_IDLE;
    pageWrC  = 1'b0;
    pageValC = 1'b0;
    if (devType == TYPE_MEM) begin
      if (sub == strapPins) begin
        selAck  = 1'b1;
        selOk   = 1'b1;
        selKind = rwBit ? K_MEMR : K_MEMW;
      end
    end else if (devType == TYPE_CTRL) begin
      if (!rwBit) begin
        if (bm.valid) begin
          selKind = K_SET;
          selOk   = hvPresent && !protQ[bm.idx];
          selAck  = selOk;
        end else if (sub == SUB_CLR) begin
          selKind = K_CLR;
          selOk   = hvPresent;
          selAck  = hvPresent;
        end else if (sub == SUB_PG0 || sub == SUB_PG1) begin
          selKind  = K_PAGE;
          selOk    = 1'b1;
          selAck   = 1'b1;
          pageWrC  = 1'b1;
          pageValC = sub[0];
        end
      end else begin
        if (bm.valid) begin
          selKind = K_QUERY;
          selAck  = !protQ[bm.idx];
        end else if (sub == SUB_PG0) begin
          selKind = K_QUERY;
          selAck  = !pageQ;
        end
      end
    end
  end

  // Address and data byte decision
  always_comb begin
    byteAck = 1'b0;
    byteArm = 1'b0;
    case (kindQ)
      K_MEMW: begin
        if (bytePos == POS_ADDR) begin
          byteAck = 1'b1;
        end else begin
          byteAck = !protQ[blkQ];
          byteArm = byteAck;
        end
      end
      K_SET, K_CLR: begin
        byteAck = okQ;
        byteArm = okQ && (bytePos != POS_ADDR);
      end
      K_PAGE:  byteAck = 1'b1;
      default: byteAck = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!porN || !rstN) begin
      kindQ      <= K_IDLE;
      okQ        <= 1'b0;
      blkQ       <= '0;
      armedQ     <= 1'b0;
      ackOut     <= 1'b0;
      wrCycleReq <= 1'b0;
    end else begin
      wrCycleReq <= 1'b0;
      if (stopValid) begin
        wrCycleReq <= armedQ;
        kindQ      <= K_IDLE;
        okQ        <= 1'b0;
        armedQ     <= 1'b0;
        ackOut     <= 1'b0;
      end else if (byteValid) begin
        if (bytePos == POS_SEL) begin
          kindQ  <= selKind;
          okQ    <= selOk;
          blkQ   <= bm.idx;
          armedQ <= 1'b0;
          ackOut <= selAck;
        end else begin
          if (kindQ == K_MEMW && bytePos == POS_ADDR) blkQ <= memBlk;
          armedQ <= byteArm;
          ackOut <= byteAck;
        end
      end
    end
  end

  always_comb begin
    strb.setMask = '0;
    strb.clrAll  = 1'b0;
    if (stopValid && armedQ && kindQ == K_SET) strb.setMask[blkQ] = 1'b1;
    if (stopValid && armedQ && kindQ == K_CLR) strb.clrAll = 1'b1;
    strb.pageWr  = takeByte && (bytePos == POS_SEL) && pageWrC;
    strb.pageVal = pageValC;
  end

  // R2: a write-cycle request only follows a stop strobe
  p_wr_after_stop_r2: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (wrCycleReq |-> $past(stopValid)));

  // R1: strap mismatch on a memory select is never acknowledged
  p_strap_mismatch_r1: assert property (@(posedge clk) disable iff (!porN || !rstN)
    ((takeByte && bytePos == POS_SEL && devType == TYPE_MEM && sub != strapPins)
      |=> !ackOut));

  // R5: protect or clear-all without high voltage is refused
  p_no_hv_refused_r5: assert property (@(posedge clk) disable iff (!porN || !rstN)
    ((takeByte && bytePos == POS_SEL && devType == TYPE_CTRL && !rwBit &&
      (bm.valid || sub == SUB_CLR) && !hvPresent) |=> !ackOut));

  // R4: at most one block is protected per command
  p_single_set_r4: assert property (@(posedge clk) disable iff (!porN || !rstN)
    ($onehot0(strb.setMask)));
endmodule

// File: rtl/spd_prot_decoder.sv
module spd_prot_decoder
  import spd_prot_pkg::*;
#(
  parameter int                BYTE_W    = 8,
  parameter int                POS_W     = 2,
  parameter int                STRAP_W   = 3,
  parameter logic [BLK_N-1:0]  PROT_INIT = '0
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               rstN,
  input  logic               byteValid,
  input  logic [BYTE_W-1:0]  byteData,
  input  logic [POS_W-1:0]   bytePos,
  input  logic               stopValid,
  input  logic [STRAP_W-1:0] strapPins,
  input  logic               hvPresent,
  output logic               ackOut,
  output logic               wrCycleReq,
  output logic               pageSel
);
  ctrlStrobe_t      strb;
  logic [BLK_N-1:0] protQ;
  logic             pageQ;

  spd_cmd_ctrl #(.BYTE_W(BYTE_W), .POS_W(POS_W), .STRAP_W(STRAP_W)) u_ctrl (
    .clk(clk), .porN(porN), .rstN(rstN),
    .byteValid(byteValid), .byteData(byteData), .bytePos(bytePos),
    .stopValid(stopValid), .strapPins(strapPins), .hvPresent(hvPresent),
    .protQ(protQ), .pageQ(pageQ),
    .strb(strb), .ackOut(ackOut), .wrCycleReq(wrCycleReq)
  );

  spd_prot_state #(.PROT_INIT(PROT_INIT)) u_state (
    .clk(clk), .porN(porN), .rstN(rstN),
    .strb(strb), .protQ(protQ), .pageQ(pageQ)
  );

  assign pageSel = pageQ;
endmodule

// File: tb/spd_prot_decoder_tb.sv
module spd_prot_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 82;

  logic       clk = 1'b0;
  logic       porN, rstN;
  logic       byteValid, stopValid, hvPresent;
  logic [7:0] byteData;
  logic [1:0] bytePos;
  logic [2:0] strapPins;
  logic       ackOut, wrCycleReq, pageSel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spd_prot_decoder u_dut (
    .clk(clk), .porN(porN), .rstN(rstN),
    .byteValid(byteValid), .byteData(byteData), .bytePos(bytePos),
    .stopValid(stopValid), .strapPins(strapPins), .hvPresent(hvPresent),
    .ackOut(ackOut), .wrCycleReq(wrCycleReq), .pageSel(pageSel)
  );

  // {req[3:0], stop, pos[1:0], data[7:0], hv, expAck, expWr}
  function automatic logic [17:0] mk(input int req, input bit stop, input int pos,
                                     input logic [7:0] d, input bit hv,
                                     input bit ea, input bit ew);
    return {4'(req), stop, 2'(pos), d, hv, ea, ew};
  endfunction

  localparam logic [17:0] VEC [NV] = '{
    // R2: memory write to unprotected block, stop after data
    mk(2,0,0,8'hAA,0,1,0), mk(2,0,1,8'h10,0,1,0), mk(2,0,2,8'h55,0,1,0), mk(2,1,0,8'h00,0,0,1),
    // R2: stop after address only
    mk(2,0,0,8'hAA,0,1,0), mk(2,0,1,8'h10,0,1,0), mk(2,1,0,8'h00,0,0,0),
    // R1: strap mismatch deselects
    mk(1,0,0,8'hA4,0,0,0), mk(1,0,1,8'h10,0,0,0), mk(1,0,2,8'h55,0,0,0), mk(1,1,0,8'h00,0,0,0),
    // R5: protect block 1 without high voltage
    mk(5,0,0,8'h68,0,0,0), mk(5,0,1,8'h00,0,0,0), mk(5,0,2,8'h00,0,0,0), mk(5,1,0,8'h00,0,0,0),
    // R4: protect block 1
    mk(4,0,0,8'h68,1,1,0), mk(4,0,1,8'h00,1,1,0), mk(4,0,2,8'h00,1,1,0), mk(4,1,0,8'h00,1,0,1),
    // R4: protect block 1 again
    mk(4,0,0,8'h68,1,0,0), mk(4,0,1,8'h00,1,0,0), mk(4,0,2,8'h00,1,0,0), mk(4,1,0,8'h00,1,0,0),
    // R7: status queries, hv ignored
    mk(7,0,0,8'h69,0,0,0), mk(7,1,0,8'h00,0,0,0), mk(7,0,0,8'h63,0,1,0), mk(7,1,0,8'h00,0,0,0),
    mk(7,0,0,8'h61,1,1,0), mk(7,1,0,8'h00,0,0,0),
    // R3: write into protected block 1 (page 0, address 80)
    mk(3,0,0,8'hAA,0,1,0), mk(3,0,1,8'h80,0,1,0), mk(3,0,2,8'h33,0,0,0), mk(3,1,0,8'h00,0,0,0),
    // R3: write into block 0 still allowed
    mk(3,0,0,8'hAA,0,1,0), mk(3,0,1,8'h7F,0,1,0), mk(3,0,2,8'h33,0,1,0), mk(3,1,0,8'h00,0,0,1),
    // R9: reserved codes
    mk(9,0,0,8'h6F,1,0,0), mk(9,1,0,8'h00,0,0,0),
    mk(9,0,0,8'h64,1,0,0), mk(9,0,1,8'h00,1,0,0), mk(9,1,0,8'h00,0,0,0),
    mk(9,0,0,8'h67,1,0,0), mk(9,1,0,8'h00,0,0,0),
    mk(9,0,0,8'h50,0,0,0), mk(9,1,0,8'h00,0,0,0),
    // R8: select page 1, query page
    mk(8,0,0,8'h6E,0,1,0), mk(8,1,0,8'h00,0,0,0), mk(8,0,0,8'h6D,0,0,0), mk(8,1,0,8'h00,0,0,0),
    // R3: page 1 address 80 is block 3, unprotected
    mk(3,0,0,8'hAA,0,1,0), mk(3,0,1,8'h80,0,1,0), mk(3,0,2,8'h12,0,1,0), mk(3,1,0,8'h00,0,0,1),
    // R4: protect block 2
    mk(4,0,0,8'h6A,1,1,0), mk(4,0,1,8'h00,1,1,0), mk(4,0,2,8'h00,1,1,0), mk(4,1,0,8'h00,1,0,1),
    // R3: page 1 address 00 is block 2, protected
    mk(3,0,0,8'hAA,0,1,0), mk(3,0,1,8'h00,0,1,0), mk(3,0,2,8'h12,0,0,0), mk(3,1,0,8'h00,0,0,0),
    // R8: back to page 0, query page
    mk(8,0,0,8'h6C,0,1,0), mk(8,1,0,8'h00,0,0,0), mk(8,0,0,8'h6D,0,1,0), mk(8,1,0,8'h00,0,0,0),
    // R5: clear-all without high voltage, block 1 stays protected
    mk(5,0,0,8'h66,0,0,0), mk(5,1,0,8'h00,0,0,0), mk(5,0,0,8'h69,0,0,0), mk(5,1,0,8'h00,0,0,0),
    // R6: clear-all, then blocks 1 and 2 read unprotected
    mk(6,0,0,8'h66,1,1,0), mk(6,0,1,8'h00,1,1,0), mk(6,0,2,8'h00,1,1,0), mk(6,1,0,8'h00,1,0,1),
    mk(6,0,0,8'h69,0,1,0), mk(6,1,0,8'h00,0,0,0), mk(6,0,0,8'h6B,0,1,0), mk(6,1,0,8'h00,0,0,0),
    // R6: clear-all with nothing protected
    mk(6,0,0,8'h66,1,1,0), mk(6,0,1,8'h00,1,1,0), mk(6,0,2,8'h00,1,1,0), mk(6,1,0,8'h00,1,0,1)
  };

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Inputs set at a falling edge, captured at the next rising edge, sampled at the next falling edge
  task automatic step(input string tag, input bit stop, input int pos, input logic [7:0] d,
                      input bit hv, input bit ea, input bit ew);
    byteValid = !stop;
    stopValid = stop;
    bytePos   = 2'(pos);
    byteData  = d;
    hvPresent = hv;
    @(negedge clk);
    check(tag, ackOut, ea, $sformatf("ackOut after byte %h", d));
    check(tag, wrCycleReq, ew, "wrCycleReq");
    byteValid = 1'b0;
    stopValid = 1'b0;
    hvPresent = 1'b0;
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    porN = 1'b0; rstN = 1'b1;
    byteValid = 1'b0; stopValid = 1'b0; hvPresent = 1'b0;
    byteData = '0; bytePos = '0; strapPins = 3'b101;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    // R10: power-on reset state
    check("R10", ackOut, 1'b0, "ackOut after power-on reset");
    check("R10", wrCycleReq, 1'b0, "wrCycleReq after power-on reset");
    check("R10", pageSel, 1'b0, "pageSel after power-on reset");

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      step($sformatf("R%0d vec%0d", v[17:14], i), v[13], int'(v[12:11]), v[10:3],
           v[2], v[1], v[0]);
    end

    // R10: protect block 0, select page 1, then soft reset
    step("R10", 0, 0, 8'h62, 1, 1, 0);
    step("R10", 0, 1, 8'h00, 1, 1, 0);
    step("R10", 0, 2, 8'h00, 1, 1, 0);
    step("R10", 1, 0, 8'h00, 0, 0, 1);
    step("R8",  0, 0, 8'h6E, 0, 1, 0);
    check("R8", pageSel, 1'b1, "pageSel after page-1 select");
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check("R10", ackOut, 1'b0, "ackOut after soft reset");
    check("R10", pageSel, 1'b0, "pageSel after soft reset");
    step("R10", 0, 0, 8'h63, 0, 0, 0);
    step("R10", 1, 0, 8'h00, 0, 0, 0);
    // R10: power-on reset returns protection to unprotected
    porN = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    step("R10", 0, 0, 8'h63, 0, 1, 0);
    step("R10", 1, 0, 8'h00, 0, 0, 0);
    // R7: a query never starts a write cycle even if followed by data bytes
    step("R7", 0, 0, 8'h63, 1, 1, 0);
    step("R7", 0, 1, 8'h00, 1, 0, 0);
    step("R7", 0, 2, 8'h00, 1, 0, 0);
    step("R7", 1, 0, 8'h00, 0, 0, 0);
    finishRun();
  end
endmodule